// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor

This block is a compact 8-bit processor built around a single accumulator. A sequencer steps every instruction through fetch, optional operand fetch and execution. All traffic to the outside goes over one byte-wide memory port, which is driven from an address register, a data register, a read/write level and a one-cycle access strobe. The memory array is not part of the block. It sits outside and answers a read on the clock edge after the strobe.

There are eleven instructions, and the parity of the opcode byte decides the instruction length. An odd opcode is followed by a two-byte address, while an even opcode stands alone. The arithmetic instructions update a zero flag and a negative flag. The other instructions leave both flags alone, so conditional branches may test flags set by an earlier instruction. A display instruction sends one memory byte to an output port together with a valid pulse. A halt instruction stops the sequencer until the next reset.

Top module: `acc_cpu`

## Requirements
- R1: While `rstN` is low, the block clears the program counter, the accumulator, the zero and negative flags and the halt flag. It also keeps `memStrobe` and `dispValid` low. After reset is released, the first memory access is a read of address 0.
- R2: The opcode bytes are 0x91 (load A from address), 0x39 (store A to address), 0x08 (clear A), 0x10 (increment A), 0x99 (add memory byte to A), 0x61 (subtract memory byte from A), 0x15 (jump), 0x17 (jump if zero flag set), 0x19 (jump if negative flag set), 0x01 (display memory byte) and 0x64 (halt). An odd opcode is followed by a 16-bit address stored high byte first. An even opcode has no operand.
- R3: Every access places the address on `memAddr` and the direction on `memRnw` (1 = read, 0 = write) no later than the cycle in which `memStrobe` is high. Both stay unchanged through the cycle after the strobe. `memStrobe` is never high in two consecutive cycles, and read data is taken from `memRdata` one cycle after the strobe.
- R4: Load copies the addressed byte into A. Store writes A to the addressed byte, with the data on `memWdata` during the write strobe.
- R5: Clear sets A to 0, sets the zero flag and clears the negative flag.
- R6: Increment, add and subtract produce 8-bit wrap-around results. They set the zero flag when the result is 0 and copy bit 7 of the result into the negative flag.
- R7: Load, store, the three jumps, display and halt leave both flags unchanged.
- R8: Jump always loads the program counter with the operand. Jump-if-zero branches only when the zero flag is 1, and jump-if-negative branches only when the negative flag is 1. A branch that is not taken continues with the next instruction.
- R9: Display reads the addressed byte and presents it on `dispData` while `dispValid` is high for exactly one cycle.
- R10: Halt sets `halted`. From then on, `halted` stays high and `memStrobe` stays low until reset.
- R11: An opcode outside the set in R2 behaves as halt.
- R12: The zero and negative flags are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| memAddr | output | ADDR_W | Address register contents |
| memWdata | output | 8 | Data register contents for writes |
| memRnw | output | 1 | 1 = read, 0 = write |
| memStrobe | output | 1 | One-cycle access request |
| memRdata | input | 8 | Read data, valid the cycle after a read strobe |
| dispData | output | 8 | Displayed byte |
| dispValid | output | 1 | One-cycle pulse qualifying dispData |
| acc | output | 8 | Accumulator |
| flagZ | output | 1 | Zero flag |
| flagN | output | 1 | Negative flag |
| halted | output | 1 | Halt flag |

## Verification
The bench tests the arithmetic edges: 0x7F+1, 0xFF+1, 0x80−1 and increments across the sign boundary. A design that takes N from a carry or a signed overflow would report the wrong flags on these cases. It also runs programs in which the flags are stale, for example a load after a clear followed by a branch on zero. A design that updates the flags on every instruction, or that reads the branch condition from the accumulator, would take the wrong path there. Further programs cover branches that are not taken, an undefined opcode, a memory write followed by a check of its address and data, and a division by repeated subtraction. An error in operand byte order or in the branch target would corrupt the displayed quotient and remainder. A halt that does not stop the sequencer would show up as strobes after `halted` rises.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int BYTE_W = 8;
  localparam int OPND_W = 2 * BYTE_W;

  localparam logic [BYTE_W-1:0] OPC_LOAD  = 8'h91;
  localparam logic [BYTE_W-1:0] OPC_STORE = 8'h39;
  localparam logic [BYTE_W-1:0] OPC_CLEAR = 8'h08;
  localparam logic [BYTE_W-1:0] OPC_INCR  = 8'h10;
  localparam logic [BYTE_W-1:0] OPC_ADD   = 8'h99;
  localparam logic [BYTE_W-1:0] OPC_SUB   = 8'h61;
  localparam logic [BYTE_W-1:0] OPC_JUMP  = 8'h15;
  localparam logic [BYTE_W-1:0] OPC_JZERO = 8'h17;
  localparam logic [BYTE_W-1:0] OPC_JNEG  = 8'h19;
  localparam logic [BYTE_W-1:0] OPC_SHOW  = 8'h01;
  localparam logic [BYTE_W-1:0] OPC_HALT  = 8'h64;

  typedef enum logic [2:0] {
    ACC_HOLD, ACC_ZERO, ACC_INC, ACC_ADD, ACC_SUB, ACC_LOAD
  } accOp_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic   marFromPc;
    logic   marFromOp;
    logic   rwRead;
    logic   rwWrite;
    logic   mdrFromMem;
    logic   mdrFromAcc;
    logic   pcInc;
    logic   pcJump;
    logic   opLoad;
    logic   hiLoad;
    logic   loLoad;
    accOp_e accOp;
    logic   haltSet;
    logic   dispFire;
  } ctrl_t;
endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
(
  input  accOp_e            op,
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] b,
  output logic [BYTE_W-1:0] res,
  output logic              zero,
  output logic              neg
);
  always_comb begin
    unique case (op)
      ACC_ZERO: res = '0;
      ACC_INC:  res = a + BYTE_W'(1);
      ACC_ADD:  res = a + b;
      ACC_SUB:  res = a - b;
      ACC_LOAD: res = b;
      default:  res = a;
    endcase
    zero = (res == '0);
    neg  = res[BYTE_W-1];
  end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [BYTE_W-1:0] memRdata,
  output logic [ADDR_W-1:0] marQ,
  output logic [BYTE_W-1:0] mdrQ,
  output logic              rwQ,
  output logic [BYTE_W-1:0] opcodeQ,
  output logic [BYTE_W-1:0] accQ,
  output logic              zQ,
  output logic              nQ,
  output logic              haltQ,
  output logic [BYTE_W-1:0] dispData,
  output logic              dispValid
);
  logic [ADDR_W-1:0] pcQ;
  logic [OPND_W-1:0] opAddrQ;
  logic [BYTE_W-1:0] aluRes;
  logic              aluZero;
  logic              aluNeg;
  logic              flagWrite;

  acc_alu u_alu (
    .op   (ctrl.accOp),
    .a    (accQ),
    .b    (mdrQ),
    .res  (aluRes),
    .zero (aluZero),
    .neg  (aluNeg)
  );

  // Load moves data but is not arithmetic; only these touch the flags
  assign flagWrite = (ctrl.accOp == ACC_ZERO) || (ctrl.accOp == ACC_INC) ||
                     (ctrl.accOp == ACC_ADD)  || (ctrl.accOp == ACC_SUB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      marQ      <= '0;
      mdrQ      <= '0;
      rwQ       <= 1'b1;
      pcQ       <= '0;
      opcodeQ   <= '0;
      opAddrQ   <= '0;
      accQ      <= '0;
      zQ        <= 1'b0;
      nQ        <= 1'b0;
      haltQ     <= 1'b0;
      dispData  <= '0;
      dispValid <= 1'b0;
    end else begin
      if (ctrl.marFromPc)      marQ <= pcQ;
      else if (ctrl.marFromOp) marQ <= opAddrQ[ADDR_W-1:0];

      if (ctrl.rwRead)       rwQ <= 1'b1;
      else if (ctrl.rwWrite) rwQ <= 1'b0;

      if (ctrl.mdrFromMem)      mdrQ <= memRdata;
      else if (ctrl.mdrFromAcc) mdrQ <= accQ;

      if (ctrl.pcJump)     pcQ <= opAddrQ[ADDR_W-1:0];
      else if (ctrl.pcInc) pcQ <= pcQ + ADDR_W'(1);

      if (ctrl.opLoad) opcodeQ <= memRdata;
      if (ctrl.hiLoad) opAddrQ[OPND_W-1:BYTE_W] <= memRdata;
      if (ctrl.loLoad) opAddrQ[BYTE_W-1:0]      <= memRdata;

      if (ctrl.accOp != ACC_HOLD) accQ <= aluRes;
      if (flagWrite) begin
        zQ <= aluZero;
        nQ <= aluNeg;
      end

      if (ctrl.haltSet) haltQ <= 1'b1;

      dispValid <= ctrl.dispFire;
      if (ctrl.dispFire) dispData <= mdrQ;
    end
  end
endmodule

// File: rtl/acc_control.sv
module acc_control
  import acc_cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] opcodeQ,
  input  logic              zQ,
  input  logic              nQ,
  output ctrl_t             ctrl,
  output logic              memStrobe
);
  typedef enum logic [3:0] {
    S_FETCH, S_OP_STB, S_OP_CAP, S_DECODE,
    S_HI_STB, S_HI_CAP, S_LO_STB, S_LO_CAP,
    S_EXEC, S_DATA_STB, S_DATA_CAP, S_FINISH,
    S_WR_STB, S_HALT
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_FETCH;
    else       state <= nextState;
  end

  always_comb begin
    ctrl      = '0;
    memStrobe = 1'b0;
    nextState = state;
    unique case (state)
      S_FETCH: begin
        ctrl.marFromPc = 1'b1;
        ctrl.rwRead    = 1'b1;
        nextState      = S_OP_STB;
      end
      S_OP_STB: begin
        memStrobe  = 1'b1;
        ctrl.pcInc = 1'b1;
        nextState  = S_OP_CAP;
      end
      S_OP_CAP: begin
        ctrl.opLoad     = 1'b1;
        ctrl.mdrFromMem = 1'b1;
        nextState       = S_DECODE;
      end
      S_DECODE: begin
        if (opcodeQ[0]) begin
          ctrl.marFromPc = 1'b1;
          ctrl.rwRead    = 1'b1;
          nextState      = S_HI_STB;
        end else begin
          nextState = S_EXEC;
        end
      end
      S_HI_STB: begin
        memStrobe  = 1'b1;
        ctrl.pcInc = 1'b1;
        nextState  = S_HI_CAP;
      end
      S_HI_CAP: begin
        ctrl.hiLoad     = 1'b1;
        ctrl.mdrFromMem = 1'b1;
        ctrl.marFromPc  = 1'b1;
        ctrl.rwRead     = 1'b1;
        nextState       = S_LO_STB;
      end
      S_LO_STB: begin
        memStrobe  = 1'b1;
        ctrl.pcInc = 1'b1;
        nextState  = S_LO_CAP;
      end
      S_LO_CAP: begin
        ctrl.loLoad     = 1'b1;
        ctrl.mdrFromMem = 1'b1;
        nextState       = S_EXEC;
      end
      S_EXEC: begin
        nextState = S_FETCH;
        case (opcodeQ)
          OPC_LOAD, OPC_ADD, OPC_SUB, OPC_SHOW: begin
            ctrl.marFromOp = 1'b1;
            ctrl.rwRead    = 1'b1;
            nextState      = S_DATA_STB;
          end
          OPC_STORE: begin
            ctrl.marFromOp  = 1'b1;
            ctrl.rwWrite    = 1'b1;
            ctrl.mdrFromAcc = 1'b1;
            nextState       = S_WR_STB;
          end
          OPC_CLEAR: ctrl.accOp  = ACC_ZERO;
          OPC_INCR:  ctrl.accOp  = ACC_INC;
          OPC_JUMP:  ctrl.pcJump = 1'b1;
          OPC_JZERO: ctrl.pcJump = zQ;
          OPC_JNEG:  ctrl.pcJump = nQ;
          default: begin
            ctrl.haltSet = 1'b1;
            nextState    = S_HALT;
          end
        endcase
      end
      S_DATA_STB: begin
        memStrobe = 1'b1;
        nextState = S_DATA_CAP;
      end
      S_DATA_CAP: begin
        ctrl.mdrFromMem = 1'b1;
        nextState       = S_FINISH;
      end
      S_FINISH: begin
        nextState = S_FETCH;
        case (opcodeQ)
          OPC_LOAD: ctrl.accOp    = ACC_LOAD;
          OPC_ADD:  ctrl.accOp    = ACC_ADD;
          OPC_SUB:  ctrl.accOp    = ACC_SUB;
          default:  ctrl.dispFire = 1'b1;
        endcase
      end
      S_WR_STB: begin
        memStrobe = 1'b1;
        nextState = S_FETCH;
      end
      S_HALT: nextState = S_HALT;
      default: nextState = S_HALT;
    endcase
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata,
  output logic              memRnw,
  output logic              memStrobe,
  input  logic [BYTE_W-1:0] memRdata,
  output logic [BYTE_W-1:0] dispData,
  output logic              dispValid,
  output logic [BYTE_W-1:0] acc,
  output logic              flagZ,
  output logic              flagN,
  output logic              halted
);
  ctrl_t             ctrl;
  logic [BYTE_W-1:0] opcodeQ;

  acc_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .opcodeQ   (opcodeQ),
    .zQ        (flagZ),
    .nQ        (flagN),
    .ctrl      (ctrl),
    .memStrobe (memStrobe)
  );

  acc_datapath #(.ADDR_W(ADDR_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .memRdata  (memRdata),
    .marQ      (memAddr),
    .mdrQ      (memWdata),
    .rwQ       (memRnw),
    .opcodeQ   (opcodeQ),
    .accQ      (acc),
    .zQ        (flagZ),
    .nQ        (flagN),
    .haltQ     (halted),
    .dispData  (dispData),
    .dispValid (dispValid)
  );
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRnw,
  input logic              memStrobe,
  input logic              dispValid,
  input logic              flagZ,
  input logic              flagN,
  input logic              halted
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    memStrobe |=> !memStrobe); // R3
  AST_ACCESS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memStrobe |=> ($stable(memAddr) && $stable(memRnw))); // R3
  AST_DISP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |=> !dispValid); // R9
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !memStrobe); // R10
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted); // R10
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(flagZ && flagN)); // R12
endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .memAddr   (memAddr),
  .memRnw    (memRnw),
  .memStrobe (memStrobe),
  .dispValid (dispValid),
  .flagZ     (flagZ),
  .flagN     (flagN),
  .halted    (halted)
);

// File: tb/test_acc_cpu.sv
module test_acc_cpu;
  localparam int ADDR_W = 16;
  localparam int MEM_N  = 256;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0]        memWdata;
  logic              memRnw;
  logic              memStrobe;
  logic [7:0]        memRdata = '0;
  logic [7:0]        dispData;
  logic              dispValid;
  logic [7:0]        acc;
  logic              flagZ;
  logic              flagN;
  logic              halted;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  acc_cpu #(.ADDR_W(ADDR_W)) i_acc_cpu (
    .clk       (clk),
    .rstN      (rstN),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .memRnw    (memRnw),
    .memStrobe (memStrobe),
    .memRdata  (memRdata),
    .dispData  (dispData),
    .dispValid (dispValid),
    .acc       (acc),
    .flagZ     (flagZ),
    .flagN     (flagN),
    .halted    (halted)
  );

  // Memory model: read data returned on the edge after the strobe
  logic [7:0] mem [MEM_N];
  logic [7:0] dispLog [8];
  int         dispCount;
  logic [15:0] lastWrAddr;
  logic [7:0]  lastWrData;

  always @(posedge clk) begin
    if (memStrobe) begin
      if (memRnw) memRdata <= mem[memAddr[7:0]];
      else begin
        mem[memAddr[7:0]] <= memWdata;
        lastWrAddr <= memAddr;
        lastWrData <= memWdata;
      end
    end
  end

  always @(posedge clk) begin
    if (!rstN) dispCount <= 0;
    else if (dispValid) begin
      if (dispCount < 8) dispLog[dispCount] <= dispData;
      dispCount <= dispCount + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic startProg();
    rstN = 1'b0;
    for (int i = 0; i < MEM_N; i++) mem[i] <= 8'h00;
  endtask

  task automatic put(input int a, input logic [7:0] v);
    mem[a] <= v;
  endtask

  task automatic release_and_run(input string tag);
    int cyc;
    int late;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cyc = 0;
    while (!halted && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    check({tag, " R10 halted reached"}, 32'(halted), 32'd1);
    late = 0;
    repeat (16) begin
      @(negedge clk);
      if (memStrobe) late++;
    end
    check({tag, " R10 no access after halt"}, late, 0);
  endtask

  // {opcode, x, y, expected A, expected Z, expected N}
  localparam logic [47:0] VEC [10] = '{
    {8'h99, 8'h05, 8'h03, 8'h08, 8'd0, 8'd0},
    {8'h99, 8'h7F, 8'h01, 8'h80, 8'd0, 8'd1},
    {8'h99, 8'hFF, 8'h01, 8'h00, 8'd1, 8'd0},
    {8'h61, 8'h05, 8'h05, 8'h00, 8'd1, 8'd0},
    {8'h61, 8'h03, 8'h07, 8'hFC, 8'd0, 8'd1},
    {8'h61, 8'h80, 8'h01, 8'h7F, 8'd0, 8'd0},
    {8'h10, 8'hFF, 8'h00, 8'h00, 8'd1, 8'd0},
    {8'h10, 8'h7F, 8'h00, 8'h80, 8'd0, 8'd1},
    {8'h08, 8'h55, 8'h00, 8'h00, 8'd1, 8'd0},
    {8'h91, 8'h80, 8'h00, 8'h00, 8'd0, 8'd0}
  };

  localparam logic [7:0] DIV_PROG [47] = '{
    8'h08, 8'h39, 8'h00, 8'h2C, 8'h91, 8'h00, 8'h2A, 8'h61, 8'h00, 8'h2B,
    8'h19, 8'h00, 8'h1D, 8'h39, 8'h00, 8'h2E, 8'h91, 8'h00, 8'h2C, 8'h10,
    8'h39, 8'h00, 8'h2C, 8'h91, 8'h00, 8'h2E, 8'h15, 8'h00, 8'h07, 8'h99,
    8'h00, 8'h2B, 8'h39, 8'h00, 8'h2D, 8'h01, 8'h00, 8'h2C, 8'h01, 8'h00,
    8'h2D, 8'h64, 8'h19, 8'h07, 8'h00, 8'h00, 8'h00
  };

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    string tag;
    logic [7:0] op;

    // R1: reset state
    startProg();
    repeat (3) @(negedge clk);
    check("R1 acc", 32'(acc), 32'h0);
    check("R1 flagZ", 32'(flagZ), 32'd0);
    check("R1 flagN", 32'(flagN), 32'd0);
    check("R1 halted", 32'(halted), 32'd0);
    check("R1 memStrobe", 32'(memStrobe), 32'd0);
    check("R1 dispValid", 32'(dispValid), 32'd0);

    // R2 R4: y = x + 1 with high-byte-first operands
    startProg();
    put(0, 8'h91); put(1, 8'h00); put(2, 8'h08);
    put(3, 8'h10);
    put(4, 8'h39); put(5, 8'h00); put(6, 8'h09);
    put(7, 8'h64); put(8, 8'h10);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    while (!memStrobe) @(negedge clk);
    check("R1 first access address", 32'(memAddr), 32'h0);
    check("R3 first access is read", 32'(memRnw), 32'd1);
    while (!halted) @(negedge clk);
    check("R4 stored byte", 32'(mem[9]), 32'h11);
    check("R4 write address", 32'(lastWrAddr), 32'h0009);
    check("R4 write data", 32'(lastWrData), 32'h11);
    check("R2 acc after program", 32'(acc), 32'h11);

    // Table of arithmetic and flag vectors
    foreach (VEC[k]) begin
      op = VEC[k][47:40];
      startProg();
      put(0, 8'h91); put(1, 8'h00); put(2, 8'h40);
      put(3, op);
      if (op[0]) begin
        put(4, 8'h00); put(5, 8'h41); put(6, 8'h64);
      end else begin
        put(4, 8'h64);
      end
      put(8'h40, VEC[k][39:32]);
      put(8'h41, VEC[k][31:24]);
      if (op == 8'h08)      tag = $sformatf("R5 vec%0d", k);
      else if (op == 8'h91) tag = $sformatf("R7 vec%0d", k);
      else                  tag = $sformatf("R6 vec%0d", k);
      release_and_run(tag);
      check({tag, " acc"}, 32'(acc), 32'(VEC[k][23:16]));
      check({tag, " flagZ"}, 32'(flagZ), 32'(VEC[k][8]));
      check({tag, " flagN"}, 32'(flagN), 32'(VEC[k][0]));
    end

    // R7 R8: stale zero flag from clear survives a load, branch taken
    startProg();
    put(0, 8'h08);
    put(1, 8'h91); put(2, 8'h00); put(3, 8'h30);
    put(4, 8'h17); put(5, 8'h00); put(6, 8'h0B);
    put(7, 8'h01); put(8, 8'h00); put(9, 8'h31);
    put(10, 8'h64);
    put(11, 8'h01); put(12, 8'h00); put(13, 8'h32);
    put(14, 8'h64);
    put(8'h30, 8'h05); put(8'h31, 8'hEE); put(8'h32, 8'h77);
    release_and_run("R8 stale-z");
    check("R7 zero flag kept over load", 32'(flagZ), 32'd1);
    check("R7 acc loaded", 32'(acc), 32'h05);
    check("R8 taken branch display count", dispCount, 1);
    check("R9 taken branch display value", 32'(dispLog[0]), 32'h77);

    // R8: branches not taken when both flags are clear
    startProg();
    put(0, 8'h91); put(1, 8'h00); put(2, 8'h30);
    put(3, 8'h19); put(4, 8'h00); put(5, 8'h0D);
    put(6, 8'h17); put(7, 8'h00); put(8, 8'h0D);
    put(9, 8'h01); put(10, 8'h00); put(11, 8'h31);
    put(12, 8'h64);
    put(13, 8'h01); put(14, 8'h00); put(15, 8'h32);
    put(16, 8'h64);
    put(8'h30, 8'h05); put(8'h31, 8'hEE); put(8'h32, 8'h77);
    release_and_run("R8 not-taken");
    check("R8 fall-through display count", dispCount, 1);
    check("R8 fall-through display value", 32'(dispLog[0]), 32'hEE);

    // R11: undefined opcode halts before the following display
    startProg();
    put(0, 8'h22);
    put(1, 8'h01); put(2, 8'h00); put(3, 8'h31);
    put(4, 8'h64);
    put(8'h31, 8'hEE);
    release_and_run("R11 undefined");
    check("R11 no display after undefined opcode", dispCount, 0);

    // R6 R8 R9: division 25 / 7 by repeated subtraction
    startProg();
    foreach (DIV_PROG[i]) put(i, DIV_PROG[i]);
    release_and_run("R9 division");
    check("R9 display count", dispCount, 2);
    check("R9 quotient", 32'(dispLog[0]), 32'd3);
    check("R9 remainder", 32'(dispLog[1]), 32'd4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule